// File: doc/BRIEF.md
# Memory ECC Error Capture Unit

This block sits beside the ECC checker of a memory controller and records what the checker reports. Each access that fails the check arrives as a one-cycle event. The event carries a correctable (single-bit) or uncorrectable (multi-bit) flag, the failing address, the 64-bit read data and the 8-bit check byte. The unit keeps sticky detect flags. It freezes the details of the first error until software clears it, and it drives one interrupt line.

Correctable errors are counted against a programmable threshold, so that a noisy bank does not raise an interrupt on every correction. A set of injection registers holds XOR masks for the data and the check byte, plus a control word. These go straight out to the datapath, which can use them to corrupt writes on purpose. Software reaches everything through a simple word-addressed 32-bit register port. Reads are combinational and writes take effect at the clock edge.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: An event with `evt_mbe` set and the uncorrectable type not disabled sets bit 1 of the detect register (word 0), visible after the clock edge that samples the event.
- R3: Writing word 0 clears each detect bit (bits 0, 1, 31) written as one, so 0xFFFFFFFF clears all of them; a detect bit set by an event in the same cycle stays set.
- R4: Word 1 bit 0 disables correctable detection and bit 1 disables uncorrectable detection; a disabled event sets no detect bit, loads no capture and does not advance the count.
- R5: Word 2 bit 0 enables the interrupt for the correctable detect bit and bit 1 for the uncorrectable one; `irq` is the registered OR of enabled detect bits, so it follows a detect bit one cycle later, and with word 2 at zero `irq` stays low.
- R6: Word 3 holds the threshold in bits 23:16 and reads the current count in bits 7:0; each enabled correctable event advances the count, and the event that brings it to the threshold sets detect bit 0 and returns the count to zero; a threshold of zero never sets the bit and holds the count at zero.
- R7: Capture registers load only on an event that sets a detect bit while all detect bits are clear; an event that would set a detect bit while one is already set sets bit 31 (multiple error) and leaves the capture unchanged.
- R8: Captured fields read as: word 4 data bits 63:32, word 5 data bits 31:0, word 6 check byte in bits 7:0, word 7 the 32-bit address.
- R9: Words 8 (data mask high), 9 (data mask low) and 10 (injection control) read back what was written and drive `inj_data_mask` ({word 8, word 9}) and `inj_ctrl`.
- R10: Word 11 bit 0 selects a 32-bit data bus; captures made in that mode store zero for data bits 63:32 and for check bits 7:4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word index of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| evt_valid | input | 1 | Error event present this cycle |
| evt_sbe | input | 1 | Event is a correctable error |
| evt_mbe | input | 1 | Event is an uncorrectable error |
| evt_addr | input | 32 | Failing address |
| evt_data | input | 64 | Read data of the failing access |
| evt_chk | input | 8 | Check byte of the failing access |
| inj_data_mask | output | 64 | Data injection mask |
| inj_ctrl | output | 32 | Injection control word |
| irq | output | 1 | Error interrupt |

## Verification
The bench builds the unit with its default parameters: a 4-bit register index, an 8-bit threshold and count, and 32-bit addresses. With these, every register word and a threshold of three are within reach. The bench can then observe the count climbing below the threshold and wrapping at it, and a threshold of zero staying silent. Collisions are driven directly: a clear and a new error in the same cycle, and a second error arriving while the first is held. The 32-bit bus mode is checked on a fresh capture.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  localparam int REG_W = 32;
  localparam logic [3:0] A_DETECT  = 4'd0;
  localparam logic [3:0] A_DISABLE = 4'd1;
  localparam logic [3:0] A_INTEN   = 4'd2;
  localparam logic [3:0] A_SBEMGT  = 4'd3;
  localparam logic [3:0] A_CAP_HI  = 4'd4;
  localparam logic [3:0] A_CAP_LO  = 4'd5;
  localparam logic [3:0] A_CAP_CHK = 4'd6;
  localparam logic [3:0] A_CAP_ADR = 4'd7;
  localparam logic [3:0] A_INJ_HI  = 4'd8;
  localparam logic [3:0] A_INJ_LO  = 4'd9;
  localparam logic [3:0] A_INJ_CTL = 4'd10;
  localparam logic [3:0] A_CONFIG  = 4'd11;
  localparam int DET_MULTI_BIT = 31;
  localparam int THR_LSB       = 16;
endpackage

// File: rtl/ecc_cfg_regs.sv
module ecc_cfg_regs
  import ecc_cap_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int THR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [1:0]        dis_q,
  output logic [1:0]        inten_q,
  output logic [THR_W-1:0]  thr_q,
  output logic              narrow_q,
  output logic [REG_W-1:0]  inj_hi_q,
  output logic [REG_W-1:0]  inj_lo_q,
  output logic [REG_W-1:0]  inj_ctl_q
);
  logic [1:0]       dis_n, inten_n;
  logic [THR_W-1:0] thr_n;
  logic             narrow_n;
  logic [REG_W-1:0] inj_hi_n, inj_lo_n, inj_ctl_n;

  always_comb begin
    dis_n     = dis_q;
    inten_n   = inten_q;
    thr_n     = thr_q;
    narrow_n  = narrow_q;
    inj_hi_n  = inj_hi_q;
    inj_lo_n  = inj_lo_q;
    inj_ctl_n = inj_ctl_q;
    if (wr_en) begin
      unique case (addr)
        ADDR_W'(A_DISABLE): dis_n     = wdata[1:0];
        ADDR_W'(A_INTEN):   inten_n   = wdata[1:0];
        ADDR_W'(A_SBEMGT):  thr_n     = wdata[THR_LSB +: THR_W];
        ADDR_W'(A_CONFIG):  narrow_n  = wdata[0];
        ADDR_W'(A_INJ_HI):  inj_hi_n  = wdata;
        ADDR_W'(A_INJ_LO):  inj_lo_n  = wdata;
        ADDR_W'(A_INJ_CTL): inj_ctl_n = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q     <= '0;
      inten_q   <= '0;
      thr_q     <= '0;
      narrow_q  <= 1'b0;
      inj_hi_q  <= '0;
      inj_lo_q  <= '0;
      inj_ctl_q <= '0;
    end else if (wr_en) begin
      dis_q     <= dis_n;
      inten_q   <= inten_n;
      thr_q     <= thr_n;
      narrow_q  <= narrow_n;
      inj_hi_q  <= inj_hi_n;
      inj_lo_q  <= inj_lo_n;
      inj_ctl_q <= inj_ctl_n;
    end
  end
endmodule

// File: rtl/ecc_sbe_thresh.sv
module ecc_sbe_thresh #(
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sbe_evt,
  input  logic [THR_W-1:0] thr,
  output logic [THR_W-1:0] cnt_q,
  output logic             hit
);
  logic [THR_W-1:0] cnt_n;
  logic [THR_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    cnt_n = cnt_q;
    hit   = 1'b0;
    if (thr == '0) begin
      cnt_n = '0;
    end else if (sbe_evt) begin
      if (cnt_inc >= {1'b0, thr}) begin
        cnt_n = '0;
        hit   = 1'b1;
      end else begin
        cnt_n = cnt_inc[THR_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  // R6: the threshold hit only fires from a live event with a nonzero limit
  p_hit_needs_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (sbe_evt && thr != '0));
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log #(
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int CW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_sbe,
  input  logic          set_mbe,
  input  logic [2:0]    clr,
  input  logic          narrow,
  input  logic [AW-1:0] evt_addr,
  input  logic [DW-1:0] evt_data,
  input  logic [CW-1:0] evt_chk,
  output logic [2:0]    det_q,
  output logic [AW-1:0] cap_addr_q,
  output logic [DW-1:0] cap_data_q,
  output logic [CW-1:0] cap_chk_q
);
  localparam int HDW = DW / 2;
  localparam int HCW = CW / 2;

  logic          any_set, load, multi_set;
  logic [2:0]    det_n;
  logic [DW-1:0] data_n;
  logic [CW-1:0] chk_n;

  assign any_set   = set_sbe | set_mbe;
  assign load      = any_set & (det_q == 3'b000);
  assign multi_set = any_set & (det_q != 3'b000);

  always_comb begin
    det_n = (det_q & ~clr) | {multi_set, set_mbe, set_sbe};
    if (narrow) begin
      data_n = {{HDW{1'b0}}, evt_data[HDW-1:0]};
      chk_n  = {{HCW{1'b0}}, evt_chk[HCW-1:0]};
    end else begin
      data_n = evt_data;
      chk_n  = evt_chk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) det_q <= '0;
    else        det_q <= det_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr_q <= '0;
      cap_data_q <= '0;
      cap_chk_q  <= '0;
    end else if (load) begin
      cap_addr_q <= evt_addr;
      cap_data_q <= data_n;
      cap_chk_q  <= chk_n;
    end
  end

  // R7: a held error keeps its capture through the next cycle
  p_capture_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (det_q != 3'b000) |=> ($stable(cap_addr_q) && $stable(cap_data_q)));
  // R2: the uncorrectable flag rises only from an uncorrectable event
  p_mbe_from_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_q[1]) |-> $past(set_mbe));
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
  import ecc_cap_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int THR_W  = 8,
  parameter int EAW    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              evt_valid,
  input  logic              evt_sbe,
  input  logic              evt_mbe,
  input  logic [EAW-1:0]    evt_addr,
  input  logic [63:0]       evt_data,
  input  logic [7:0]        evt_chk,
  output logic [63:0]       inj_data_mask,
  output logic [31:0]       inj_ctrl,
  output logic              irq
);
  logic [1:0]       dis_q, inten_q;
  logic [THR_W-1:0] thr_q, cnt_q;
  logic             narrow_q, sbe_ok, mbe_ok, sbe_hit, irq_n;
  logic [31:0]      inj_hi_q, inj_lo_q;
  logic [2:0]       det_q, clr;
  logic [EAW-1:0]   cap_addr_q;
  logic [63:0]      cap_data_q;
  logic [7:0]       cap_chk_q;

  ecc_cfg_regs #(.ADDR_W(ADDR_W), .THR_W(THR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .dis_q(dis_q), .inten_q(inten_q), .thr_q(thr_q),
    .narrow_q(narrow_q), .inj_hi_q(inj_hi_q), .inj_lo_q(inj_lo_q),
    .inj_ctl_q(inj_ctrl)
  );

  assign sbe_ok = evt_valid & evt_sbe & ~dis_q[0];
  assign mbe_ok = evt_valid & evt_mbe & ~dis_q[1];
  assign clr    = (reg_wr && reg_addr == ADDR_W'(A_DETECT))
                  ? {reg_wdata[DET_MULTI_BIT], reg_wdata[1:0]} : 3'b000;

  ecc_sbe_thresh #(.THR_W(THR_W)) u_thr (
    .clk(clk), .rst_n(rst_n), .sbe_evt(sbe_ok), .thr(thr_q),
    .cnt_q(cnt_q), .hit(sbe_hit)
  );

  ecc_err_log #(.AW(EAW), .DW(64), .CW(8)) u_log (
    .clk(clk), .rst_n(rst_n), .set_sbe(sbe_hit), .set_mbe(mbe_ok),
    .clr(clr), .narrow(narrow_q), .evt_addr(evt_addr), .evt_data(evt_data),
    .evt_chk(evt_chk), .det_q(det_q), .cap_addr_q(cap_addr_q),
    .cap_data_q(cap_data_q), .cap_chk_q(cap_chk_q)
  );

  assign inj_data_mask = {inj_hi_q, inj_lo_q};
  assign irq_n         = |(det_q[1:0] & inten_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_n;
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_W'(A_DETECT):  reg_rdata = {det_q[2], 29'b0, det_q[1:0]};
      ADDR_W'(A_DISABLE): reg_rdata = {30'b0, dis_q};
      ADDR_W'(A_INTEN):   reg_rdata = {30'b0, inten_q};
      ADDR_W'(A_SBEMGT):  begin
        reg_rdata[THR_LSB +: THR_W] = thr_q;
        reg_rdata[THR_W-1:0]        = cnt_q;
      end
      ADDR_W'(A_CAP_HI):  reg_rdata = cap_data_q[63:32];
      ADDR_W'(A_CAP_LO):  reg_rdata = cap_data_q[31:0];
      ADDR_W'(A_CAP_CHK): reg_rdata = {24'b0, cap_chk_q};
      ADDR_W'(A_CAP_ADR): reg_rdata = 32'(cap_addr_q);
      ADDR_W'(A_INJ_HI):  reg_rdata = inj_hi_q;
      ADDR_W'(A_INJ_LO):  reg_rdata = inj_lo_q;
      ADDR_W'(A_INJ_CTL): reg_rdata = inj_ctrl;
      ADDR_W'(A_CONFIG):  reg_rdata = {31'b0, narrow_q};
      default:            reg_rdata = '0;
    endcase
  end

  // R4: a disabled correctable type never raises its detect flag
  p_sbe_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_q[0]) |-> $past(evt_valid && evt_sbe && !dis_q[0]));
  // R5: with every enable clear the interrupt line is low a cycle later
  p_irq_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inten_q == 2'b00) |=> !irq);
endmodule

// File: tb/sim_ecc_err_capture.sv
module sim_ecc_err_capture;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        evt_valid, evt_sbe, evt_mbe;
  logic [31:0] evt_addr;
  logic [63:0] evt_data;
  logic [7:0]  evt_chk;
  logic [63:0] inj_data_mask;
  logic [31:0] inj_ctrl;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  ecc_err_capture u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_valid(evt_valid),
    .evt_sbe(evt_sbe), .evt_mbe(evt_mbe), .evt_addr(evt_addr),
    .evt_data(evt_data), .evt_chk(evt_chk), .inj_data_mask(inj_data_mask),
    .inj_ctrl(inj_ctrl), .irq(irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic evt(input logic s, input logic m, input logic [31:0] a,
                     input logic [63:0] d, input logic [7:0] c);
    @(negedge clk);
    evt_valid = 1'b1; evt_sbe = s; evt_mbe = m;
    evt_addr = a; evt_data = d; evt_chk = c;
    @(negedge clk);
    evt_valid = 1'b0; evt_sbe = 1'b0; evt_mbe = 1'b0;
  endtask

  task automatic t_reset;
    for (int i = 0; i < 12; i++) rd_check("R1", 4'(i), 32'h0);
    check("R1 irq", 64'(irq), 64'h0);
  endtask

  task automatic t_mbe_capture;
    wr(4'd2, 32'h2);
    evt(1'b0, 1'b1, 32'h1000_0040, 64'hDEAD_BEEF_1234_5678, 8'hA5);
    rd_check("R2", 4'd0, 32'h2);
    rd_check("R8 hi", 4'd4, 32'hDEAD_BEEF);
    rd_check("R8 lo", 4'd5, 32'h1234_5678);
    rd_check("R8 chk", 4'd6, 32'hA5);
    rd_check("R8 addr", 4'd7, 32'h1000_0040);
    check("R5 irq", 64'(irq), 64'h1);
    evt(1'b0, 1'b1, 32'h2000_0000, 64'h1, 8'h01);
    rd_check("R7 multi", 4'd0, 32'h8000_0002);
    rd_check("R7 addr kept", 4'd7, 32'h1000_0040);
    wr(4'd0, 32'hFFFF_FFFF);
    rd_check("R3 clear all", 4'd0, 32'h0);
    @(negedge clk);
    check("R5 irq drop", 64'(irq), 64'h0);
  endtask

  task automatic t_threshold;
    wr(4'd3, 32'h0003_0000);
    wr(4'd2, 32'h1);
    evt(1'b1, 1'b0, 32'h30, 64'h5, 8'h3);
    evt(1'b1, 1'b0, 32'h31, 64'h6, 8'h4);
    rd_check("R6 count", 4'd3, 32'h0003_0002);
    rd_check("R6 below", 4'd0, 32'h0);
    evt(1'b1, 1'b0, 32'h32, 64'h7, 8'h5);
    rd_check("R6 hit", 4'd0, 32'h1);
    rd_check("R6 wrap", 4'd3, 32'h0003_0000);
    rd_check("R7 load on hit", 4'd7, 32'h32);
    check("R6 irq", 64'(irq), 64'h1);
    wr(4'd0, 32'h1);
    rd_check("R3 clear one", 4'd0, 32'h0);
    wr(4'd3, 32'h0);
    evt(1'b1, 1'b0, 32'h33, 64'h8, 8'h6);
    evt(1'b1, 1'b0, 32'h34, 64'h9, 8'h7);
    rd_check("R6 zero thr", 4'd0, 32'h0);
    rd_check("R6 zero cnt", 4'd3, 32'h0);
  endtask

  task automatic t_disable;
    wr(4'd3, 32'h0001_0000);
    wr(4'd1, 32'h3);
    evt(1'b1, 1'b1, 32'h44, 64'h44, 8'h44);
    rd_check("R4 no detect", 4'd0, 32'h0);
    rd_check("R4 no capture", 4'd7, 32'h32);
    wr(4'd1, 32'h0);
    rd_check("R4 reenable", 4'd1, 32'h0);
  endtask

  task automatic t_mask;
    wr(4'd2, 32'h0);
    evt(1'b0, 1'b1, 32'h55, 64'h55, 8'h55);
    rd_check("R5 detect", 4'd0, 32'h2);
    @(negedge clk);
    check("R5 masked", 64'(irq), 64'h0);
    wr(4'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_set_wins;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 32'hFFFF_FFFF;
    evt_valid = 1'b1; evt_mbe = 1'b1; evt_addr = 32'h66;
    evt_data = 64'h66; evt_chk = 8'h66;
    @(negedge clk);
    reg_wr = 1'b0; evt_valid = 1'b0; evt_mbe = 1'b0;
    rd_check("R3 set wins", 4'd0, 32'h2);
    wr(4'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_narrow;
    wr(4'd11, 32'h1);
    rd_check("R10 cfg", 4'd11, 32'h1);
    evt(1'b0, 1'b1, 32'h77, 64'hCAFE_F00D_8765_4321, 8'hB7);
    rd_check("R10 hi", 4'd4, 32'h0);
    rd_check("R10 lo", 4'd5, 32'h8765_4321);
    rd_check("R10 chk", 4'd6, 32'h07);
    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd11, 32'h0);
  endtask

  task automatic t_inject;
    wr(4'd8, 32'h8000_0001);
    wr(4'd9, 32'h0000_0100);
    wr(4'd10, 32'h0000_01FF);
    rd_check("R9 hi", 4'd8, 32'h8000_0001);
    rd_check("R9 lo", 4'd9, 32'h0000_0100);
    rd_check("R9 ctl", 4'd10, 32'h0000_01FF);
    check("R9 mask out", inj_data_mask, 64'h8000_0001_0000_0100);
    check("R9 ctl out", 64'(inj_ctrl), 64'h1FF);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    evt_valid = 1'b0; evt_sbe = 1'b0; evt_mbe = 1'b0;
    evt_addr = '0; evt_data = '0; evt_chk = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mbe_capture();
    t_threshold();
    t_disable();
    t_mask();
    t_set_wins();
    t_narrow();
    t_inject();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule